// File: doc/BRIEF.md
# Energy Pulse Threshold Accumulator

This block turns slow per-phase power samples into a stream of energy quanta. Each channel chooses one of five power flavours (total active, total reactive, apparent, fundamental active, fundamental reactive) and sums the chosen flavour over the phases its enable mask allows. New samples are captured on a slow sample strobe, around 8 kHz. The captured values are then re-added on every fast accumulation tick, around 1 MHz. Re-adding the held value at the fast rate, and keeping the residue after each subtraction, spreads the quanta evenly in time and so reduces ripple in any pulse train built from them.

On each tick the phase sum is shifted left by seven bits and added to a signed accumulator. When the magnitude of the accumulator reaches the programmed threshold (also shifted left by seven), the channel raises a one-cycle quantum strobe. It then moves the accumulator toward zero by one threshold and latches the sign of the phase sum as a reverse-power flag. A downstream pulse shaper consumes the strobes. Both strobes are clock enables on a single system clock. The design assumes that one tick's increment stays below one threshold, so one subtraction per tick is enough.

Top module: `energy_quantum_acc`

## Requirements
- R1: Selector code 000 picks total active power, 001 total reactive, 010 apparent, 011 fundamental active and 100 fundamental reactive. Each channel has a 3-bit field in `cfg_sel`, with channel k at bits [3k+2:3k].
- R2: Selector codes 101, 110 and 111 add zero on a tick. A channel set to one of them never emits a quantum and keeps its reverse flag.
- R3: Mask bit 0 enables phase A, bit 1 phase B and bit 2 phase C. Channel k's mask is `cfg_mask` [3k+2:3k]. Only enabled phases enter the signed sum, and phase p of each power bus sits at bits [27p+26:27p].
- R4: On each cycle with `acc_tick` high, the channel adds its signed phase sum times 128 to its signed accumulator.
- R5: If the updated accumulator is at least thr*128, `quantum` is high for exactly the next cycle and thr*128 is subtracted. The residue is kept.
- R6: If the updated accumulator is at most -thr*128, `quantum` is high for exactly the next cycle and thr*128 is added. The residue is kept.
- R7: On each quantum, `rev_flag` takes the sign bit of the phase sum (1 means negative). The flag holds its value between quanta.
- R8: After reset, all accumulators are zero, `quantum` and `rev_flag` are low, all masks are 111, and the channel selectors are 000, 001 and 010 (channel k defaults to k).
- R9: The power buses are captured only on cycles with `samp_stb` high. Every later tick uses the captured values until the next strobe.
- R10: A threshold of zero produces no quanta.
- R11: `quantum` is never high except in the cycle after an `acc_tick` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_stb | input | 1 | Slow sample capture strobe |
| acc_tick | input | 1 | Fast accumulation tick strobe |
| pw_tot_act | input | 81 | Total active power, three signed 27-bit phases |
| pw_tot_react | input | 81 | Total reactive power, three phases |
| pw_apparent | input | 81 | Apparent power, three phases |
| pw_fund_act | input | 81 | Fundamental active power, three phases |
| pw_fund_react | input | 81 | Fundamental reactive power, three phases |
| thr | input | 48 | Energy threshold before the seven-bit scaling |
| cfg_wr | input | 1 | Load selector and mask fields |
| cfg_sel | input | 9 | Per-channel flavour selectors |
| cfg_mask | input | 9 | Per-channel phase enable masks |
| quantum | output | 3 | Per-channel one-cycle energy quantum strobe |
| rev_flag | output | 3 | Per-channel sign of phase sum at the last quantum |

## Verification
The assertions check four rules on every cycle: quanta appear only after a tick, a zero threshold never yields one, a reserved selector never yields one, and the reverse flag never changes except alongside a quantum. The exact accumulation arithmetic can only be shown by the bench's sweeps. These cover every selector code against every mask at two thresholds and check each tick against an arithmetic model. The sweeps also cover residue carry-over, the negative-side subtraction, sample capture only on the strobe, and the reset defaults.

// File: rtl/eqa_pkg.sv
// Shared constants and types for the energy quantum accumulator.
package eqa_pkg;
    localparam int NFLAV = 5;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        FL_TOT_ACT    = 3'd0,
        FL_TOT_REACT  = 3'd1,
        FL_APPARENT   = 3'd2,
        FL_FUND_ACT   = 3'd3,
        FL_FUND_REACT = 3'd4
    } flav_e;

    // True when a selector code names an implemented flavour.
    function automatic logic sel_valid(logic [SEL_W-1:0] s);
        return s < SEL_W'(NFLAV);
    endfunction
endpackage

// File: rtl/eqa_sample_hold.sv
// Captures all flavour/phase power samples on the slow strobe.
// Assumes: the strobe is a single-cycle clock enable.
module eqa_sample_hold #(
    parameter int W = 405
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         samp_stb,
    input  logic [W-1:0] smp_in,
    output logic [W-1:0] smp_q
);
    // Hold register, loaded only on the sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        smp_q <= '0;
        else if (samp_stb) smp_q <= smp_in;
    end
endmodule

// File: rtl/eqa_phase_sum.sv
// Selects one flavour and sums the enabled phases as signed values.
// Assumes: flavour f, phase p lives at bits [(f*NPH+p)*PW +: PW].
// A reserved selector yields zero.
module eqa_phase_sum
    import eqa_pkg::*;
#(
    parameter int NPH   = 3,
    parameter int PW    = 27,
    parameter int SUM_W = PW + $clog2(NPH) + 1
) (
    input  logic [NFLAV*NPH*PW-1:0]  smp,
    input  logic [SEL_W-1:0]         sel,
    input  logic [NPH-1:0]           mask,
    output logic signed [SUM_W-1:0]  sum
);
    // Combinational select, mask and signed add.
    always_comb begin
        sum = '0;
        if (sel_valid(sel)) begin
            for (int p = 0; p < NPH; p++) begin
                if (mask[p]) begin
                    sum = sum + SUM_W'($signed(smp[(int'(sel)*NPH + p)*PW +: PW]));
                end
            end
        end
    end
endmodule

// File: rtl/eqa_accum.sv
// Signed energy accumulator with a symmetric threshold and subtract.
// Assumes: one tick's increment (sum << SHIFT) is below thr << SHIFT,
// so a single correction per tick keeps the residue bounded.
module eqa_accum #(
    parameter int SUM_W = 29,
    parameter int SHIFT = 7,
    parameter int THR_W = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic signed [SUM_W-1:0] sum,
    input  logic [THR_W-1:0]        thr,
    output logic                    quantum,
    output logic                    rev
);
    localparam int T_W   = THR_W + SHIFT;
    localparam int ACC_W = T_W + 2;
    localparam int INC_W = SUM_W + SHIFT;

    logic signed [INC_W-1:0] inc;
    logic signed [ACC_W-1:0] acc_q, acc_add, thr_ext, acc_nxt;
    logic                    pos_hit, neg_hit;

    // Scale the sum, add it and compare the magnitude against the threshold.
    always_comb begin
        inc     = {sum, {SHIFT{1'b0}}};
        thr_ext = {2'b00, thr, {SHIFT{1'b0}}};
        acc_add = acc_q + ACC_W'(inc);
        pos_hit = (|thr) && (acc_add >= thr_ext);
        neg_hit = (|thr) && (acc_add <= -thr_ext);
        if (pos_hit)      acc_nxt = acc_add - thr_ext;
        else if (neg_hit) acc_nxt = acc_add + thr_ext;
        else              acc_nxt = acc_add;
    end

    // Register the accumulator, the quantum strobe and the sign flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            quantum <= 1'b0;
            rev     <= 1'b0;
        end else begin
            quantum <= tick && (pos_hit || neg_hit);
            if (tick) begin
                acc_q <= acc_nxt;
                if (pos_hit || neg_hit) rev <= sum[SUM_W-1];
            end
        end
    end
endmodule

// File: rtl/energy_quantum_acc.sv
// Multi-channel energy quantum generator. Holds the slow samples, and per
// channel selects a flavour, sums masked phases and accumulates at the tick.
// Assumes: samp_stb and acc_tick are single-cycle clock enables on clk.
module energy_quantum_acc
    import eqa_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int NPH   = 3,
    parameter int PW    = 27,
    parameter int THR_W = 48,
    parameter int SHIFT = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 samp_stb,
    input  logic                 acc_tick,
    input  logic [NPH*PW-1:0]    pw_tot_act,
    input  logic [NPH*PW-1:0]    pw_tot_react,
    input  logic [NPH*PW-1:0]    pw_apparent,
    input  logic [NPH*PW-1:0]    pw_fund_act,
    input  logic [NPH*PW-1:0]    pw_fund_react,
    input  logic [THR_W-1:0]     thr,
    input  logic                 cfg_wr,
    input  logic [NCH*SEL_W-1:0] cfg_sel,
    input  logic [NCH*NPH-1:0]   cfg_mask,
    output logic [NCH-1:0]       quantum,
    output logic [NCH-1:0]       rev_flag
);
    localparam int BUS_W = NFLAV * NPH * PW;
    localparam int SUM_W = PW + $clog2(NPH) + 1;

    logic [BUS_W-1:0]       smp_in, smp_q;
    logic [NCH*SEL_W-1:0]   sel_q;
    logic [NCH*NPH-1:0]     mask_q;

    assign smp_in = {pw_fund_react, pw_fund_act, pw_apparent, pw_tot_react, pw_tot_act};

    eqa_sample_hold #(.W(BUS_W)) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_stb (samp_stb),
        .smp_in   (smp_in),
        .smp_q    (smp_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [SEL_W-1:0] SEL_DEF = SEL_W'(g % NFLAV);
        logic signed [SUM_W-1:0] sum;

        // Per-channel configuration registers with their reset defaults.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[g*SEL_W +: SEL_W] <= SEL_DEF;
                mask_q[g*NPH +: NPH]    <= '1;
            end else if (cfg_wr) begin
                sel_q[g*SEL_W +: SEL_W] <= cfg_sel[g*SEL_W +: SEL_W];
                mask_q[g*NPH +: NPH]    <= cfg_mask[g*NPH +: NPH];
            end
        end

        eqa_phase_sum #(.NPH(NPH), .PW(PW), .SUM_W(SUM_W)) sum_i (
            .smp  (smp_q),
            .sel  (sel_q[g*SEL_W +: SEL_W]),
            .mask (mask_q[g*NPH +: NPH]),
            .sum  (sum)
        );

        eqa_accum #(.SUM_W(SUM_W), .SHIFT(SHIFT), .THR_W(THR_W)) acc_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (acc_tick),
            .sum     (sum),
            .thr     (thr),
            .quantum (quantum[g]),
            .rev     (rev_flag[g])
        );
    end
endmodule

// File: rtl/eqa_chk.sv
// Property checker for energy_quantum_acc, attached by bind.
module eqa_chk #(
    parameter int NCH   = 3,
    parameter int THR_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_tick,
    input logic [THR_W-1:0] thr,
    input logic [NCH*3-1:0] sel_q,
    input logic [NCH-1:0]   quantum,
    input logic [NCH-1:0]   rev_flag
);
    // R11
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|quantum) |-> $past(acc_tick));

    // R10
    zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_tick && thr == '0) |=> (quantum == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_c
        // R2
        reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_tick && sel_q[g*3 +: 3] > 3'd4) |=> !quantum[g]);

        // R7
        rev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(rev_flag[g]) |-> quantum[g]);
    end
endmodule

bind energy_quantum_acc eqa_chk #(.NCH(NCH), .THR_W(THR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_tick (acc_tick),
    .thr      (thr),
    .sel_q    (sel_q),
    .quantum  (quantum),
    .rev_flag (rev_flag)
);

// File: tb/energy_quantum_acc_tb.sv
module energy_quantum_acc_tb_top;
    localparam int NCH = 3, NPH = 3, PW = 27, THR_W = 48;

    logic clk = 0, rst_n = 0, samp_stb = 0, acc_tick = 0, cfg_wr = 0;
    logic [NPH*PW-1:0] bus [5];
    logic [THR_W-1:0]  thr = '0;
    logic [NCH*3-1:0]  cfg_sel = '0;
    logic [NCH*NPH-1:0] cfg_mask = '0;
    logic [NCH-1:0]    quantum, rev_flag;

    int checks = 0, failures = 0;
    longint macc [NCH];
    bit     mrev [NCH];
    int     msel [NCH], mmask [NCH];
    int     held [5][NPH];
    int     vals [5][NPH];

    always #5 clk = ~clk;

    energy_quantum_acc dut_i (
        .clk(clk), .rst_n(rst_n), .samp_stb(samp_stb), .acc_tick(acc_tick),
        .pw_tot_act(bus[0]), .pw_tot_react(bus[1]), .pw_apparent(bus[2]),
        .pw_fund_act(bus[3]), .pw_fund_react(bus[4]), .thr(thr),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_mask(cfg_mask),
        .quantum(quantum), .rev_flag(rev_flag)
    );

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint msum(int ch);
        longint s = 0;
        if (msel[ch] > 4) return 0;               // R2 reserved codes add zero
        for (int p = 0; p < NPH; p++)
            if (mmask[ch][p]) s += held[msel[ch]][p]; // R1 flavour, R3 mask
        return s;
    endfunction

    task automatic drive_bus();
        for (int f = 0; f < 5; f++)
            for (int p = 0; p < NPH; p++)
                bus[f][p*PW +: PW] = PW'(vals[f][p]);
    endtask

    // Put values on the buses; capture them only when strobe is set (R9).
    task automatic load(bit strobe);
        @(negedge clk);
        drive_bus();
        samp_stb = strobe;
        @(negedge clk);
        samp_stb = 0;
        if (strobe) held = vals;
    endtask

    task automatic write_cfg(int s [NCH], int m [NCH]);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            cfg_sel[c*3 +: 3]  = 3'(s[c]);
            cfg_mask[c*3 +: 3] = 3'(m[c]);
        end
        cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
        msel = s;
        mmask = m;
    endtask

    // One tick, then check quanta (R4, R5, R6, R7) and the idle cycle (R11).
    task automatic tick();
        longint t = longint'(thr) * 128;
        @(negedge clk);
        acc_tick = 1;
        @(negedge clk);
        acc_tick = 0;
        for (int c = 0; c < NCH; c++) begin
            longint s = msum(c);
            longint a = macc[c] + s * 128;
            bit q = 0;
            if (t != 0 && a >= t) begin a -= t; q = 1; end
            else if (t != 0 && a <= -t) begin a += t; q = 1; end
            if (q) mrev[c] = (s < 0);
            macc[c] = a;
            chk(quantum[c] == q, "R5/R6 quantum", longint'(quantum[c]), longint'(q));
            chk(rev_flag[c] == mrev[c], "R7 rev_flag", longint'(rev_flag[c]), longint'(mrev[c]));
        end
        @(negedge clk);
        chk(quantum == '0, "R11 no quantum without tick", longint'(quantum), 0);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int s [NCH];
        int m [NCH];
        for (int f = 0; f < 5; f++) bus[f] = '0;
        for (int c = 0; c < NCH; c++) begin
            macc[c] = 0; mrev[c] = 0; msel[c] = c; mmask[c] = 7;
        end
        for (int f = 0; f < 5; f++)
            for (int p = 0; p < NPH; p++) begin
                vals[f][p] = (f + 1) * (p + 1);
                if (f == 1 || (f == 4 && p == 1)) vals[f][p] = -vals[f][p];
                held[f][p] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8 reset outputs
        chk(quantum == '0, "R8 reset quantum", longint'(quantum), 0);
        chk(rev_flag == '0, "R8 reset rev_flag", longint'(rev_flag), 0);

        thr = 48'd37;
        load(1);
        // R8 default selectors 0,1,2 and full masks, seen through quanta
        for (int k = 0; k < 12; k++) tick();

        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) begin
                thr = 48'd53;
                for (int f = 0; f < 5; f++)
                    for (int p = 0; p < NPH; p++) vals[f][p] = -vals[f][p] + p;
                load(1);
            end
            for (int sc = 0; sc < 8; sc++)
                for (int mk = 0; mk < 8; mk++) begin
                    s[0] = sc; m[0] = mk;
                    s[1] = (sc + 3) % 8; m[1] = 7 - mk;
                    s[2] = (sc + 1) % 5; m[2] = mk | 1;
                    write_cfg(s, m);
                    // R9: noise on the buses without a strobe is ignored
                    begin
                        int save [5][NPH];
                        save = vals;
                        for (int f = 0; f < 5; f++)
                            for (int p = 0; p < NPH; p++)
                                vals[f][p] = 20000 * (f + 1) + 777 * p + sc;
                        load(0);
                        vals = save;
                    end
                    for (int k = 0; k < 10; k++) tick();
                end
        end

        // R10: zero threshold never produces a quantum
        thr = '0;
        for (int k = 0; k < 10; k++) tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule